// File: doc/BRIEF.md
# Flow-Through SEC-DED Memory Error Corrector

This block sits on the data lines between a memory controller and a 72-bit wide memory data path. Going toward memory, it takes 64-bit system words, registers them once and sends them out unchanged, together with 8 check bits computed from the word. Coming back from memory, it latches a 64-bit data word and its 8 stored check bits. It then computes the check bits again from the latched data and XORs them with the stored ones to form an 8-bit syndrome. A single flipped bit anywhere in the 72-bit code word is repaired. A flipped check bit leaves the data untouched. Two flipped bits are reported but not repaired.

Both directions are valid/ready streams. Each one runs through a single holding stage. An item moves when valid and ready are both high at a rising clock edge. A stage offers ready while it is empty, or while its downstream side is taking the item it currently holds. A stalled output keeps its value until it is taken. The two directions share nothing and may move in the same cycle. The error flags and the syndrome are plain status outputs. They belong to the read word presented in the same cycle.

Top module: `edac_flow_unit`

## Requirements
- R1: A system word accepted on the write stream appears unchanged on `mem_wr_data` with `mem_wr_valid` high from the next cycle onward, and write items leave in the order they were accepted.
- R2: Data bit i has an 8-bit column code. The codes are taken from all 8-bit values of weight 3 in ascending numeric order (56 of them), then from values of weight 5 in ascending order, until bits 0..63 each have one. Check bit j is the XOR of all data bits whose column has bit j set. Check bit j itself has the column with only bit j set.
- R3: On each stream, the input ready is high when the stage is empty or the output is being taken. A stalled output holds its valid and payload stable. No item is lost or duplicated. Both output valids are low after reset.
- R4: The memory data and check bits are captured at the read handshake. The result is computed from the captured word only. Changes on `mem_rd_data`/`mem_rd_check` after capture have no effect on it.
- R5: If the read code word has no error, the syndrome is zero, the data is returned unchanged and both flags are low.
- R6: If one data bit i is flipped, the syndrome equals the column of bit i, the bit is inverted back, `rd_single_err` is 1 and `rd_double_err` is 0.
- R7: If one check bit j is flipped, the syndrome has only bit j set, the data is returned unchanged and `rd_single_err` is 1.
- R8: If any two bits are flipped, the syndrome is nonzero with even weight, `rd_double_err` is 1, `rd_single_err` is 0 and the data is returned as read, without correction.
- R9: `rd_syndrome` is always the stored check bits XOR the check bits computed from the latched data, and the two flags are never high together.
- R10: A write and a read may be accepted and delivered in the same cycles without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_wr_valid | input | 1 | System write word valid |
| sys_wr_ready | output | 1 | Write stage can accept |
| sys_wr_data | input | 64 | System write word |
| mem_wr_valid | output | 1 | Memory-side write word valid |
| mem_wr_ready | input | 1 | Memory side takes the write word |
| mem_wr_data | output | 64 | Forwarded write data |
| mem_wr_check | output | 8 | Generated check bits |
| mem_rd_valid | input | 1 | Memory read word valid |
| mem_rd_ready | output | 1 | Read latch can capture |
| mem_rd_data | input | 64 | Data read from memory |
| mem_rd_check | input | 8 | Check bits read from memory |
| sys_rd_valid | output | 1 | Checked read word valid |
| sys_rd_ready | input | 1 | System takes the read word |
| sys_rd_data | output | 64 | Corrected read data |
| rd_single_err | output | 1 | Single-bit error found and corrected |
| rd_double_err | output | 1 | Double-bit error found, not corrected |
| rd_syndrome | output | 8 | Syndrome of the presented read word |

## Verification
The write-side check-bit generation and the read-side correction can fall in the same cycle, because their stages are fully separate. The bench provokes this by forking a write sequence and a read sequence with error injection, so that both handshakes and both outputs overlap while independent pseudo-random ready patterns stall each side. The scoreboard queues for the two directions are kept apart. Each write word and each corrected read word is judged against its own expected item. Any interference between the two paths would show up as a data, check-bit, flag or syndrome mismatch, or as an item out of order.

// File: rtl/edac_pkg.sv
package edac_pkg;
  localparam int DATA_W = 64;

  // smallest c with 2^(c-1) >= DATA_W + c
  function automatic int calc_chk_w(input int d);
    int c;
    c = 1;
    while ((1 << (c - 1)) < (d + c)) c++;
    return c;
  endfunction

  localparam int CHK_W  = calc_chk_w(DATA_W);
  localparam int CODE_W = DATA_W + CHK_W;

  // column code of data bit idx: odd weights >= 3, ascending inside each weight
  function automatic logic [CHK_W-1:0] col_code(input int idx);
    logic [CHK_W-1:0] res;
    logic [CHK_W-1:0] cand;
    int n;
    res = '0;
    n   = 0;
    for (int w = 3; w <= CHK_W; w += 2) begin
      for (int v = 0; v < (1 << CHK_W); v++) begin
        cand = CHK_W'(v);
        if ($countones(cand) == w) begin
          if (n == idx) res = cand;
          n++;
        end
      end
    end
    return res;
  endfunction

  // data bits feeding check bit j
  function automatic logic [DATA_W-1:0] row_mask(input int j);
    logic [DATA_W-1:0] m;
    logic [CHK_W-1:0]  c;
    for (int i = 0; i < DATA_W; i++) begin
      c    = col_code(i);
      m[i] = c[j];
    end
    return m;
  endfunction

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [CHK_W-1:0]  chk;
  } code_word_t;
endpackage

// File: rtl/edac_check_gen.sv
module edac_check_gen
  import edac_pkg::*;
(
  input  logic [DATA_W-1:0] data_in,
  output logic [CHK_W-1:0]  chk_out
);
  for (genvar j = 0; j < CHK_W; j++) begin : g_row
    localparam logic [DATA_W-1:0] MASK = row_mask(j);
    assign chk_out[j] = ^(data_in & MASK);
  end
endmodule

// File: rtl/edac_pipe_reg.sv
module edac_pipe_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  logic             full_q;
  logic [WIDTH-1:0] data_q;

  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_ready) begin
      full_q <= in_valid;
      if (in_valid) data_q <= in_data;
    end
  end

  // R3: a stalled item stays put
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R4: the accepted word is what the stage presents next
  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));
endmodule

// File: rtl/edac_decode.sv
module edac_decode
  import edac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [DATA_W-1:0] raw_data,
  input  logic [CHK_W-1:0]  raw_chk,
  output logic [DATA_W-1:0] fix_data,
  output logic [CHK_W-1:0]  syndrome,
  output logic              single_err,
  output logic              double_err
);
  logic [CHK_W-1:0]  regen_chk;
  logic [DATA_W-1:0] flip;
  logic              chk_hit;

  edac_check_gen u_regen (
    .data_in (raw_data),
    .chk_out (regen_chk)
  );

  assign syndrome = raw_chk ^ regen_chk;

  for (genvar i = 0; i < DATA_W; i++) begin : g_col
    localparam logic [CHK_W-1:0] COL = col_code(i);
    assign flip[i] = (syndrome == COL);
  end

  assign chk_hit    = $onehot(syndrome);
  assign single_err = (|flip) || chk_hit;
  assign double_err = (syndrome != '0) && !single_err;
  assign fix_data   = raw_data ^ flip;

  // R9: never both classes at once
  a_r9_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> !(single_err && double_err));

  // R5: clean word passes untouched
  a_r5_clean_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && syndrome == '0) |-> (fix_data == raw_data && !single_err && !double_err));

  // R7: check-bit-only error leaves data alone
  a_r7_check_only: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && $countones(syndrome) == 1) |-> (fix_data == raw_data && single_err));

  // R8: even nonzero syndrome is a double error, uncorrected
  a_r8_even_double: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && syndrome != '0 && !($countones(syndrome) % 2 == 1))
      |-> (double_err && fix_data == raw_data));
endmodule

// File: rtl/edac_flow_unit.sv
module edac_flow_unit
  import edac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_wr_valid,
  output logic              sys_wr_ready,
  input  logic [63:0]       sys_wr_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [63:0]       mem_wr_data,
  output logic [7:0]        mem_wr_check,
  input  logic              mem_rd_valid,
  output logic              mem_rd_ready,
  input  logic [63:0]       mem_rd_data,
  input  logic [7:0]        mem_rd_check,
  output logic              sys_rd_valid,
  input  logic              sys_rd_ready,
  output logic [63:0]       sys_rd_data,
  output logic              rd_single_err,
  output logic              rd_double_err,
  output logic [7:0]        rd_syndrome
);
  // write direction: generate on entry, hold word and check bits together
  code_word_t wr_in, wr_out;
  logic [CHK_W-1:0] wr_chk;

  edac_check_gen u_wr_gen (
    .data_in (sys_wr_data),
    .chk_out (wr_chk)
  );

  assign wr_in = '{data: sys_wr_data, chk: wr_chk};

  edac_pipe_reg #(.WIDTH(CODE_W)) u_wr_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (sys_wr_valid),
    .in_ready  (sys_wr_ready),
    .in_data   (wr_in),
    .out_valid (mem_wr_valid),
    .out_ready (mem_wr_ready),
    .out_data  (wr_out)
  );

  assign mem_wr_data  = wr_out.data;
  assign mem_wr_check = wr_out.chk;

  // read direction: latch code word, then check and correct
  code_word_t rd_in, rd_latched;

  assign rd_in = '{data: mem_rd_data, chk: mem_rd_check};

  edac_pipe_reg #(.WIDTH(CODE_W)) u_rd_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (mem_rd_valid),
    .in_ready  (mem_rd_ready),
    .in_data   (rd_in),
    .out_valid (sys_rd_valid),
    .out_ready (sys_rd_ready),
    .out_data  (rd_latched)
  );

  edac_decode u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_valid (sys_rd_valid),
    .raw_data   (rd_latched.data),
    .raw_chk    (rd_latched.chk),
    .fix_data   (sys_rd_data),
    .syndrome   (rd_syndrome),
    .single_err (rd_single_err),
    .double_err (rd_double_err)
  );
endmodule

// File: tb/tb_edac_flow_unit.sv
module tb_edac_flow_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sys_wr_valid = 1'b0;
  logic        sys_wr_ready;
  logic [63:0] sys_wr_data = '0;
  logic        mem_wr_valid;
  logic        mem_wr_ready = 1'b1;
  logic [63:0] mem_wr_data;
  logic [7:0]  mem_wr_check;
  logic        mem_rd_valid = 1'b0;
  logic        mem_rd_ready;
  logic [63:0] mem_rd_data = '0;
  logic [7:0]  mem_rd_check = '0;
  logic        sys_rd_valid;
  logic        sys_rd_ready = 1'b1;
  logic [63:0] sys_rd_data;
  logic        rd_single_err;
  logic        rd_double_err;
  logic [7:0]  rd_syndrome;

  edac_flow_unit dut (.*);

  always #5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  bit in_reset = 1'b1;

  logic [7:0] cols [64];

  typedef struct {
    logic [63:0] data;
    logic [7:0]  chk;
    string       tag;
  } wr_item_t;

  typedef struct {
    logic [63:0] data;
    logic        s;
    logic        d;
    logic [7:0]  syn;
    string       tag;
  } rd_item_t;

  wr_item_t wr_q[$];
  rd_item_t rd_q[$];

  function automatic logic [7:0] gen(input logic [63:0] d);
    logic [7:0] c = '0;
    for (int i = 0; i < 64; i++) if (d[i]) c ^= cols[i];
    return c;
  endfunction

  task automatic report(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic drive_wr(input logic [63:0] d, input string tag);
    wr_item_t it;
    @(posedge clk); #1;
    sys_wr_valid = 1'b1;
    sys_wr_data  = d;
    @(negedge clk);
    while (!sys_wr_ready) @(negedge clk);
    it.data = d; it.chk = gen(d); it.tag = tag;
    wr_q.push_back(it);
    @(posedge clk); #1;
    sys_wr_valid = 1'b0;
    sys_wr_data  = ~d;
  endtask

  task automatic drive_rd(input logic [63:0] d, input logic [63:0] fd, input logic [7:0] fc, input string tag);
    rd_item_t it;
    logic [7:0] c;
    int nf;
    c  = gen(d);
    nf = $countones(fd) + $countones(fc);
    @(posedge clk); #1;
    mem_rd_valid = 1'b1;
    mem_rd_data  = d ^ fd;
    mem_rd_check = c ^ fc;
    @(negedge clk);
    while (!mem_rd_ready) @(negedge clk);
    it.syn  = gen(d ^ fd) ^ (c ^ fc);
    it.s    = (nf == 1);
    it.d    = (nf == 2);
    it.data = (nf == 2) ? (d ^ fd) : d;
    it.tag  = tag;
    rd_q.push_back(it);
    @(posedge clk); #1;
    mem_rd_valid = 1'b0;
    // R4: garbage on the memory side after capture must not matter
    mem_rd_data  = {32{2'b10}} ^ d;
    mem_rd_check = ~mem_rd_check;
  endtask

  // monitors
  always @(negedge clk) begin
    if (!in_reset && mem_wr_valid && mem_wr_ready) begin
      if (wr_q.size() == 0) report(1'b0, "R3 unexpected write item", {64'h0, mem_wr_data}, 128'h0);
      else begin
        wr_item_t e;
        e = wr_q.pop_front();
        report(mem_wr_data == e.data, {e.tag, " R1 write data"}, {64'h0, mem_wr_data}, {64'h0, e.data});
        report(mem_wr_check == e.chk, {e.tag, " R2 check bits"}, {120'h0, mem_wr_check}, {120'h0, e.chk});
      end
    end
    if (!in_reset && sys_rd_valid && sys_rd_ready) begin
      if (rd_q.size() == 0) report(1'b0, "R3 unexpected read item", {64'h0, sys_rd_data}, 128'h0);
      else begin
        rd_item_t e;
        e = rd_q.pop_front();
        report(sys_rd_data == e.data, {e.tag, " R4 read data"}, {64'h0, sys_rd_data}, {64'h0, e.data});
        report({rd_single_err, rd_double_err} == {e.s, e.d}, {e.tag, " R9 flags s,d"},
               {126'h0, rd_single_err, rd_double_err}, {126'h0, e.s, e.d});
        report(rd_syndrome == e.syn, {e.tag, " R9 syndrome"}, {120'h0, rd_syndrome}, {120'h0, e.syn});
      end
    end
  end

  // pseudo-random back-pressure on both outputs (R3)
  logic [15:0] lfsr = 16'hACE1;
  initial begin
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (!in_reset) begin
        mem_wr_ready = lfsr[0] | lfsr[3];
        sys_rd_ready = lfsr[5] | lfsr[9];
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired R3 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int n;
    n = 0;
    for (int w = 3; w <= 8; w += 2)
      for (int v = 0; v < 256; v++)
        if (n < 64 && $countones(v[7:0]) == w) begin
          cols[n] = v[7:0];
          n++;
        end

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R3: reset state
    report(!mem_wr_valid && !sys_rd_valid, "R3 reset valids",
           {126'h0, mem_wr_valid, sys_rd_valid}, 128'h0);
    in_reset = 1'b0;

    // write path alone
    drive_wr(64'h0, "R2");
    drive_wr('1, "R2");
    for (int i = 0; i < 64; i += 7) drive_wr(64'h1 << i, "R2");
    for (int k = 0; k < 8; k++) drive_wr({lfsr, ~lfsr, lfsr ^ 16'h5A5A, 16'(k) * 16'h1357}, "R1");

    // read path: clean words
    drive_rd(64'h0, '0, '0, "R5");
    drive_rd('1, '0, '0, "R5");
    drive_rd(64'hDEAD_BEEF_0123_4567, '0, '0, "R5");

    // every single data-bit error
    for (int i = 0; i < 64; i++)
      drive_rd(64'hF0E1_D2C3_B4A5_9687 ^ (64'(i) << 17), 64'h1 << i, '0, "R6");
    // every single check-bit error
    for (int j = 0; j < 8; j++)
      drive_rd(64'h0F1E_2D3C_4B5A_6978 + 64'(j), '0, 8'h1 << j, "R7");
    // double errors across data and check positions
    for (int k = 0; k < 40; k++) begin
      int p, q;
      logic [63:0] fd;
      logic [7:0]  fc;
      p = (k * 5) % 72;
      q = (k * 11 + 7) % 72;
      if (p != q) begin
        fd = '0; fc = '0;
        if (p < 64) fd[p] = 1'b1; else fc[p-64] = 1'b1;
        if (q < 64) fd[q] = 1'b1; else fc[q-64] = 1'b1;
        drive_rd(64'h3333_5555_AAAA_CCCC ^ (64'(k) << 40), fd, fc, "R8");
      end
    end

    // R10: both directions at once
    fork
      for (int k = 0; k < 24; k++) drive_wr(64'h1111_0000_0000_0000 * 64'(k + 1) ^ 64'(k), "R10");
      for (int k = 0; k < 24; k++)
        drive_rd(64'h0123_4567_89AB_CDEF + 64'(k * 977), 64'h1 << (k * 3 % 64),
                 (k % 3 == 0) ? 8'h1 << (k % 8) : 8'h0, "R10");
    join

    // drain
    for (int t = 0; t < 200 && (wr_q.size() != 0 || rd_q.size() != 0); t++) @(posedge clk);
    report(wr_q.size() == 0 && rd_q.size() == 0, "R3 items all delivered",
           128'(wr_q.size() + rd_q.size()), 128'h0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule